// File: doc/BRIEF.md
# Packet Trace Serializer

This block copies every packet byte that passes between the radio packet engine and its buffer onto three outgoing wires: a trace clock, a trace data line and a frame line. An external capture tool clocks in the data line and the frame line on the rising edge of the trace clock. Both lines change only together with the clock's falling edge. Each packet opens with one marker bit that tells transmit from receive, followed by the packet bytes, least-significant bit first. The frame line stays high from the marker to the last bit of the packet.

The packet path offers bytes with start, end and direction flags. The block only observes them and has no ready signal, so it can never slow the packet path down. A small FIFO absorbs bursts. A byte that finds the FIFO full is dropped, and a sticky flag records the loss. The trace clock is the system clock divided by a parameter, and it runs only while packet bits go out. A single enable input decides who owns the three pads. While the block is disabled and idle, the pads carry the general-purpose output values. If the block is disabled in the middle of a packet, it first finishes the current byte, then drives all three lines low for one bit time, and only then releases the pads.

Top module: `pkt_trace_ser`

## Requirements
- R1: After reset, `drop_flag` is 0, `pad_own` is 0 and `pad_out` equals `gpio_dout`.
- R2: While `trace_en` is 0 and no packet or tail is in progress, `pad_own` is 0 and `pad_out` equals `gpio_dout`. Bit 0 is the trace clock, bit 1 the trace data and bit 2 the frame line.
- R3: The first bit time of a packet is a marker bit. During it the frame is high and the data line is 1 for a transmit packet (`pkt_is_tx`=1) and 0 for a receive packet.
- R4: After the marker, each byte goes out least-significant bit first. When the next byte is already queued, it follows with no pause. The frame stays high throughout.
- R5: In every bit, the trace clock is low for `HALF_DIV` system cycles and then high for `HALF_DIV` system cycles. Data and frame change only on the cycle where the clock goes low. The clock is never high while the frame is low.
- R6: After the last bit of the byte flagged `pkt_last`, the frame falls. All three lines then stay low for one bit time before the pads can be released.
- R7: If the next byte of a packet has not arrived when a byte ends, the trace clock stays low and the frame stays high until that byte arrives.
- R8: The FIFO holds `FIFO_DEPTH` (at least 4) bytes. A byte offered while the FIFO is full is dropped and sets `drop_flag`, which stays 1 until reset. The packet input is never stalled.
- R9: Clearing `trace_en` during a packet lets the current byte finish. The frame then falls, the low tail bit time follows, the queued bytes are discarded, and the pads return to `gpio_dout`.
- R10: Bytes offered while `trace_en` is 0 are ignored. A queued byte without `pkt_first` that arrives while the serializer is idle is discarded and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Enables tracing and takes ownership of the pads |
| pkt_valid | input | 1 | A packet byte is present this cycle |
| pkt_byte | input | 8 | Packet byte value |
| pkt_first | input | 1 | Byte is the first byte of a packet |
| pkt_last | input | 1 | Byte is the last byte of a packet |
| pkt_is_tx | input | 1 | Packet direction, 1 transmit, 0 receive |
| gpio_dout | input | 3 | General-purpose values for the pads when released |
| pad_out | output | 3 | Pad values: {frame, data, clock} |
| pad_own | output | 1 | 1 while the serializer owns the pads |
| drop_flag | output | 1 | Sticky FIFO overflow indication |

## Verification
The hardest conditions to reach are the FIFO overflow in the middle of a packet and a disable that lands inside a byte. The bench reaches the overflow by pushing eight bytes on consecutive cycles. One byte leaves the FIFO at once, four are stored, and the remaining three are dropped, including the one that carries the end flag. The packet then stalls with the frame high until the enable is cleared. For the disable case, the bench clears the enable a few bits into the first of two queued bytes. The scoreboard then expects only that byte, followed by the frame fall. A later packet confirms that the flushed byte never comes out.

// File: rtl/pkt_trace_pkg.sv
package pkt_trace_pkg;

  typedef struct packed {
    logic       first;
    logic       last;
    logic       is_tx;
    logic [7:0] data;
  } trc_item_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MARK,
    ST_DATA,
    ST_GAP,
    ST_TAIL
  } trc_state_t;

endpackage

// File: rtl/ptl_fifo.sv
module ptl_fifo
  import pkt_trace_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  trc_item_t push_item,
  input  logic      pop,
  output trc_item_t head,
  output logic      empty,
  output logic      full,
  output logic [LW-1:0] level
);

  trc_item_t         mem [DEPTH];
  logic [AW-1:0]     wp_q, wp_n, rp_q, rp_n;
  logic [LW-1:0]     cnt_q, cnt_n;
  logic              do_push, do_pop;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == LW'(DEPTH));
  assign head  = mem[rp_q];
  assign level = cnt_q;

  always_comb begin
    do_push = push & ~full & ~flush;
    do_pop  = pop & ~empty & ~flush;
    wp_n    = wp_q;
    rp_n    = rp_q;
    cnt_n   = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = wp_q + AW'(1);
      if (do_pop)  rp_n = rp_q + AW'(1);
      if (do_push && !do_pop)      cnt_n = cnt_q + LW'(1);
      else if (do_pop && !do_push) cnt_n = cnt_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_item;
  end

endmodule

// File: rtl/ptl_baud.sv
module ptl_baud #(
  parameter int HALF_DIV = 500,
  localparam int PERIOD = 2 * HALF_DIV,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hi_half,
  output logic bit_end
);

  localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HALF_CNT = CW'(HALF_DIV);

  logic [CW-1:0] cnt_q, cnt_n;

  assign hi_half = run & (cnt_q >= HALF_CNT);
  assign bit_end = run & (cnt_q == LAST_CNT);

  always_comb begin
    if (!run || cnt_q == LAST_CNT) cnt_n = '0;
    else                           cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/ptl_shift.sv
module ptl_shift
  import pkt_trace_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      empty,
  input  trc_item_t head,
  input  logic      hi_half,
  input  logic      bit_end,
  output logic      pop,
  output logic      run,
  output logic      busy,
  output logic      trc_clk,
  output logic      trc_data,
  output logic      trc_frame
);

  trc_state_t state_q, state_n;
  logic [7:0] sh_q, sh_n;
  logic [2:0] bidx_q, bidx_n;
  logic       last_q, last_n;
  logic       dir_q, dir_n;
  logic       oclk_n, odata_n, oframe_n;

  always_comb begin
    state_n = state_q;
    sh_n    = sh_q;
    bidx_n  = bidx_q;
    last_n  = last_q;
    dir_n   = dir_q;
    pop     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (en && !empty) begin
          pop = 1'b1;
          if (head.first) begin
            state_n = ST_MARK;
            sh_n    = head.data;
            last_n  = head.last;
            dir_n   = head.is_tx;
          end
        end
      end
      ST_MARK: begin
        if (bit_end) begin
          state_n = en ? ST_DATA : ST_TAIL;
          bidx_n  = '0;
        end
      end
      ST_DATA: begin
        if (bit_end) begin
          if (bidx_q == 3'd7) begin
            bidx_n = '0;
            if (last_q || !en) begin
              state_n = ST_TAIL;
            end else if (!empty) begin
              pop    = 1'b1;
              sh_n   = head.data;
              last_n = head.last;
            end else begin
              state_n = ST_GAP;
            end
          end else begin
            sh_n   = {1'b0, sh_q[7:1]};
            bidx_n = bidx_q + 3'd1;
          end
        end
      end
      ST_GAP: begin
        if (!en) begin
          state_n = ST_TAIL;
        end else if (!empty) begin
          pop     = 1'b1;
          sh_n    = head.data;
          last_n  = head.last;
          bidx_n  = '0;
          state_n = ST_DATA;
        end
      end
      ST_TAIL: begin
        if (bit_end) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    run      = (state_q == ST_MARK) || (state_q == ST_DATA) || (state_q == ST_TAIL);
    busy     = (state_q != ST_IDLE);
    oclk_n   = 1'b0;
    odata_n  = 1'b0;
    oframe_n = 1'b0;
    unique case (state_q)
      ST_MARK: begin oclk_n = hi_half; odata_n = dir_q;   oframe_n = 1'b1; end
      ST_DATA: begin oclk_n = hi_half; odata_n = sh_q[0]; oframe_n = 1'b1; end
      ST_GAP:  begin oframe_n = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      bidx_q    <= '0;
      last_q    <= 1'b0;
      dir_q     <= 1'b0;
      trc_clk   <= 1'b0;
      trc_data  <= 1'b0;
      trc_frame <= 1'b0;
    end else begin
      state_q   <= state_n;
      sh_q      <= sh_n;
      bidx_q    <= bidx_n;
      last_q    <= last_n;
      dir_q     <= dir_n;
      trc_clk   <= oclk_n;
      trc_data  <= odata_n;
      trc_frame <= oframe_n;
    end
  end

endmodule

// File: rtl/pkt_trace_ser.sv
module pkt_trace_ser
  import pkt_trace_pkg::*;
#(
  parameter int HALF_DIV   = 500,
  parameter int FIFO_DEPTH = 4,
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trace_en,
  input  logic       pkt_valid,
  input  logic [7:0] pkt_byte,
  input  logic       pkt_first,
  input  logic       pkt_last,
  input  logic       pkt_is_tx,
  input  logic [2:0] gpio_dout,
  output logic [2:0] pad_out,
  output logic       pad_own,
  output logic       drop_flag
);

  trc_item_t        in_item, head;
  logic             fifo_empty, fifo_full, fifo_push, fifo_pop;
  logic [LVL_W-1:0] fifo_level;
  logic             hi_half, bit_end, run, busy;
  logic             trc_clk, trc_data, trc_frame;
  logic             drop_n;

  assign in_item   = '{first: pkt_first, last: pkt_last, is_tx: pkt_is_tx, data: pkt_byte};
  assign fifo_push = pkt_valid & trace_en;

  ptl_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (~trace_en),
    .push      (fifo_push),
    .push_item (in_item),
    .pop       (fifo_pop),
    .head      (head),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .level     (fifo_level)
  );

  ptl_baud #(.HALF_DIV(HALF_DIV)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .hi_half (hi_half),
    .bit_end (bit_end)
  );

  ptl_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (trace_en),
    .empty     (fifo_empty),
    .head      (head),
    .hi_half   (hi_half),
    .bit_end   (bit_end),
    .pop       (fifo_pop),
    .run       (run),
    .busy      (busy),
    .trc_clk   (trc_clk),
    .trc_data  (trc_data),
    .trc_frame (trc_frame)
  );

  always_comb begin
    drop_n = drop_flag | (fifo_push & fifo_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_flag <= 1'b0;
    else        drop_flag <= drop_n;
  end

  assign pad_own = trace_en | busy;
  assign pad_out = pad_own ? {trc_frame, trc_data, trc_clk} : gpio_dout;

endmodule

// File: rtl/ptl_check.sv
module ptl_check #(
  parameter int DEPTH = 4,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trace_en,
  input logic          pkt_valid,
  input logic          fifo_full,
  input logic [LW-1:0] fifo_level,
  input logic          trc_clk,
  input logic          trc_data,
  input logic          trc_frame,
  input logic          pad_own,
  input logic          drop_flag
);

  // R5: clock pulses only inside a frame
  a_r5_clk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    trc_clk |-> trc_frame);

  // R5: lines hold steady while the clock stays high
  a_r5_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_clk && $past(trc_clk)) |-> ($stable(trc_data) && $stable(trc_frame)));

  // R3: a frame opens with the clock low
  a_r3_frame_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trc_frame) |-> !trc_clk);

  // R8: full FIFO plus offered byte sets the flag
  a_r8_drop_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && trace_en && fifo_full) |=> drop_flag);

  // R8: flag is sticky
  a_r8_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    drop_flag |=> drop_flag);

  // R8: fill level bounded by depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  // R2: released pads never leave a frame open
  a_r2_release_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_own |-> !trc_frame);

endmodule

bind pkt_trace_ser ptl_check #(.DEPTH(FIFO_DEPTH), .LW(LVL_W)) u_check (
  .clk        (clk),
  .rst_n      (rst_n),
  .trace_en   (trace_en),
  .pkt_valid  (pkt_valid),
  .fifo_full  (fifo_full),
  .fifo_level (fifo_level),
  .trc_clk    (trc_clk),
  .trc_data   (trc_data),
  .trc_frame  (trc_frame),
  .pad_own    (pad_own),
  .drop_flag  (drop_flag)
);

// File: tb/test_pkt_trace_ser.sv
`timescale 1ns/1ps
module test_pkt_trace_ser;

  localparam int HALF = 4;
  localparam int BITT = 2 * HALF;
  localparam int END_ITEM = 2;

  logic       clk;
  logic       rst_n;
  logic       trace_en;
  logic       pkt_valid;
  logic [7:0] pkt_byte;
  logic       pkt_first, pkt_last, pkt_is_tx;
  logic [2:0] gpio_dout;
  logic [2:0] pad_out;
  logic       pad_own;
  logic       drop_flag;

  int checks;
  int errors;
  int cyc;
  int expq[$];

  pkt_trace_ser #(.HALF_DIV(HALF), .FIFO_DEPTH(4)) i_pkt_trace_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .trace_en  (trace_en),
    .pkt_valid (pkt_valid),
    .pkt_byte  (pkt_byte),
    .pkt_first (pkt_first),
    .pkt_last  (pkt_last),
    .pkt_is_tx (pkt_is_tx),
    .gpio_dout (gpio_dout),
    .pad_out   (pad_out),
    .pad_own   (pad_own),
    .drop_flag (drop_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    chk(expq.size() == 0, "R4 scoreboard drained", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // scoreboard monitor
  logic [2:0] prev_pad;
  logic       prev_own;
  int         hi_len;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_pad = '0;
      prev_own = 1'b0;
      hi_len   = 0;
    end else begin
      if (pad_own && prev_own) begin
        if (pad_out[0] && !prev_pad[0]) begin
          hi_len = 1;
          if (expq.size() == 0) chk(1'b0, "R4 unexpected bit", pad_out[1], -1);
          else begin
            int e;
            e = expq.pop_front();
            chk(e != END_ITEM, "R6 frame open past end", pad_out[1], e);
            chk(pad_out[2] == 1'b1, "R3 frame high with bit", pad_out[2], 1);
            chk(pad_out[1] == e[0], "R4 bit value", pad_out[1], e);
          end
        end else if (pad_out[0]) begin
          hi_len++;
        end
        if (!pad_out[0] && prev_pad[0]) chk(hi_len == HALF, "R5 high time", hi_len, HALF);
        if (!pad_out[2] && prev_pad[2]) begin
          if (expq.size() == 0) chk(1'b0, "R6 unexpected frame end", 0, END_ITEM);
          else begin
            int e;
            e = expq.pop_front();
            chk(e == END_ITEM, "R6 frame end position", e, END_ITEM);
          end
        end
      end
      prev_pad = pad_out;
      prev_own = pad_own;
    end
  end

  task automatic exp_byte(input logic [7:0] b, input bit first, input bit last, input bit tx);
    if (first) expq.push_back(tx ? 1 : 0);
    for (int i = 0; i < 8; i++) expq.push_back(int'(b[i]));
    if (last) expq.push_back(END_ITEM);
  endtask

  task automatic push_byte(input logic [7:0] b, input bit first, input bit last, input bit tx);
    pkt_valid = 1'b1;
    pkt_byte  = b;
    pkt_first = first;
    pkt_last  = last;
    pkt_is_tx = tx;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic wait_drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (BITT + 4) @(negedge clk);
  endtask

  task automatic wait_frame_low();
    while (pad_out[2] == 1'b1) @(negedge clk);
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    cyc       = 0;
    rst_n     = 1'b0;
    trace_en  = 1'b0;
    pkt_valid = 1'b0;
    pkt_byte  = '0;
    pkt_first = 1'b0;
    pkt_last  = 1'b0;
    pkt_is_tx = 1'b0;
    gpio_dout = 3'b110;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(drop_flag == 1'b0, "R1 drop flag", drop_flag, 0);
    chk(pad_own == 1'b0, "R1 pad ownership", pad_own, 0);
    chk(pad_out == gpio_dout, "R1 pads follow gpio", pad_out, gpio_dout);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 mux while disabled
    for (int g = 0; g < 8; g++) begin
      gpio_dout = 3'(g);
      @(negedge clk);
      chk(pad_out == 3'(g) && !pad_own, "R2 released pads", pad_out, g);
    end

    // R10 bytes offered while disabled
    gpio_dout = 3'b010;
    push_byte(8'hA5, 1, 1, 1);
    repeat (40) @(negedge clk);
    chk(pad_out == 3'b010, "R10 ignored while disabled", pad_out, 3'b010);
    gpio_dout = 3'b000;

    // R3/R4 transmit packet, three bytes back to back
    trace_en = 1'b1;
    @(negedge clk);
    chk(pad_own == 1'b1 && pad_out == 3'b000, "R2 owned pads idle low", pad_out, 0);
    exp_byte(8'h3C, 1, 0, 1);
    exp_byte(8'h81, 0, 0, 1);
    exp_byte(8'hF0, 0, 1, 1);
    push_byte(8'h3C, 1, 0, 1);
    push_byte(8'h81, 0, 0, 1);
    push_byte(8'hF0, 0, 1, 1);
    wait_drain();

    // R10 lone byte without first flag is discarded, then R3 receive packet
    push_byte(8'hFF, 0, 0, 0);
    repeat (BITT * 2) @(negedge clk);
    chk(pad_out == 3'b000, "R10 orphan byte silent", pad_out, 0);
    exp_byte(8'h5A, 1, 0, 0);
    exp_byte(8'h01, 0, 1, 0);
    push_byte(8'h5A, 1, 0, 0);
    push_byte(8'h01, 0, 1, 0);
    wait_drain();

    // R7 late second byte
    exp_byte(8'hC3, 1, 0, 1);
    exp_byte(8'h7E, 0, 1, 1);
    push_byte(8'hC3, 1, 0, 1);
    repeat (90) @(negedge clk);
    chk(pad_out[2] == 1'b1, "R7 frame held in gap", pad_out[2], 1);
    chk(pad_out[0] == 1'b0, "R7 clock parked low", pad_out[0], 0);
    repeat (8) @(negedge clk);
    chk(pad_out[0] == 1'b0 && pad_out[2], "R7 still parked", pad_out, 3'b100);
    push_byte(8'h7E, 0, 1, 1);
    wait_frame_low();
    @(negedge clk);
    chk(pad_out == 3'b000, "R6 tail lines low", pad_out, 0);
    wait_drain();

    // R9 disable inside the first byte
    gpio_dout = 3'b101;
    exp_byte(8'h96, 1, 0, 0);
    expq.push_back(END_ITEM);
    push_byte(8'h96, 1, 0, 0);
    push_byte(8'h44, 0, 1, 0);
    repeat (30) @(negedge clk);
    trace_en = 1'b0;
    chk(pad_own == 1'b1, "R9 pads held during byte", pad_own, 1);
    wait_frame_low();
    @(negedge clk);
    chk(pad_own == 1'b1 && pad_out == 3'b000, "R9 tail low before release", pad_out, 0);
    repeat (BITT + 2) @(negedge clk);
    chk(pad_own == 1'b0 && pad_out == 3'b101, "R9 pads released", pad_out, 3'b101);
    chk(expq.size() == 0, "R9 only current byte sent", expq.size(), 0);
    gpio_dout = 3'b000;

    // R9 flushed byte never appears
    trace_en = 1'b1;
    @(negedge clk);
    exp_byte(8'h0F, 1, 1, 1);
    push_byte(8'h0F, 1, 1, 1);
    wait_drain();

    // R8 overflow
    chk(drop_flag == 1'b0, "R8 no drop yet", drop_flag, 0);
    exp_byte(8'h11, 1, 0, 1);
    exp_byte(8'h22, 0, 0, 1);
    exp_byte(8'h33, 0, 0, 1);
    exp_byte(8'h44, 0, 0, 1);
    exp_byte(8'h55, 0, 0, 1);
    push_byte(8'h11, 1, 0, 1);
    push_byte(8'h22, 0, 0, 1);
    push_byte(8'h33, 0, 0, 1);
    push_byte(8'h44, 0, 0, 1);
    push_byte(8'h55, 0, 0, 1);
    push_byte(8'h66, 0, 0, 1);
    push_byte(8'h77, 0, 0, 1);
    push_byte(8'h88, 0, 1, 1);
    chk(drop_flag == 1'b1, "R8 drop flag set", drop_flag, 1);
    while (expq.size() != 0) @(negedge clk);
    repeat (BITT * 3) @(negedge clk);
    chk(pad_out[2] == 1'b1 && pad_out[0] == 1'b0, "R7 stalled after drop", pad_out, 3'b100);
    expq.push_back(END_ITEM);
    trace_en = 1'b0;
    wait_frame_low();
    repeat (BITT + 4) @(negedge clk);
    chk(pad_own == 1'b0, "R9 released after stall", pad_own, 0);

    trace_en = 1'b1;
    @(negedge clk);
    exp_byte(8'hE7, 1, 1, 0);
    push_byte(8'hE7, 1, 1, 0);
    wait_drain();
    chk(drop_flag == 1'b1, "R8 drop flag sticky", drop_flag, 1);

    finish_run();
  end

endmodule